// File: doc/BRIEF.md
# Output Scaling and Power Ramp

This block is a per-channel gain stage for a transmit sample path. Each signed input sample is first attenuated by a coarse power-of-two shift. It is then multiplied by a fine gain between 0 and 2. Last, it is multiplied by a ramp gain word read from a small on-chip ramp memory. The ramp stage can be switched off, which makes it an exact unity pass. When it is on, a ramp-up or ramp-down strobe makes it step through the programmed memory words, one word per accepted sample. This lets the channel power rise or fall smoothly before it settles on a held word.

Samples move through a two-stage pipeline with valid/ready handshakes on both sides. A transfer happens on any clock edge where valid and ready are both high. The upstream side must hold `in_valid` and `in_data` steady until the transfer. When `out_ready` is low, `out_valid` and `out_data` stay frozen. A full pipeline then lowers `in_ready` in the same cycle, so back-pressure reaches the input without loss and without reordering. The control fields are plain level inputs and the strobes are plain one-cycle pulses. The ramp memory is written through a plain synchronous write port.

Top module: `ost_gain_ramp`

## Requirements
- R1: While reset is active and just after it is released, `out_valid` is 0 and `in_ready` is 1. The ramp sequencer comes out of reset idle, holding at the last programmed index.
- R2: Samples transfer on valid&&ready. A sample accepted at edge k is presented on the output after edge k+1 when `out_ready` is high. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold. Samples leave in order, each exactly once.
- R3: The coarse stage comes first. It arithmetically shifts the sample right by `coarse_sel` bits, 0 to 3.
- R4: The fine stage multiplies the shifted value by the unsigned 16-bit `fine_gain`, where 32768 is unity. The result is round((v*fine_gain)/2^15), with halves rounded toward positive infinity: (p + 2^14) >>> 15.
- R5: Each multiplier result is saturated to the range -32768 to 32767 and never wraps.
- R6: When `ramp_en` is 0, the output equals the fine-stage result exactly.
- R7: When `ramp_en` is 1, the output is sat((y*w + 2^13) >>> 14). Here y is the fine-stage result and w is the unsigned 14-bit ramp word, read as a fraction in [0,1).
- R8: When no ramp is stepping, w is the word at index `ramp_last`. After a completed ramp-down, w is the word at index 0 until a ramp-up completes.
- R9: A `ramp_up` pulse taken while idle with `ramp_en`=1 starts a ramp-up. The following accepted samples use the words at indices 0, 1, ... up to `ramp_last`, one per sample, and the sequencer then returns to idle. A sample accepted in the same cycle as the pulse still uses the idle word. If both strobes arrive together, ramp-up wins.
- R10: A `ramp_down` pulse taken while idle with `ramp_en`=1 starts a ramp-down. The following accepted samples use the words at indices `ramp_last` down to 0, one per sample.
- R11: A strobe that arrives while a ramp is stepping has no effect. A strobe that arrives while `ramp_en` is 0 has no effect.
- R12: All gains applied to a sample come from the control field values present in the cycle that sample is accepted. A field change made after acceptance does not affect that sample.
- R13: A ramp memory write takes effect at the clock edge. A sample accepted at the same edge that reads the written index uses the old word, and the next sample uses the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream can accept a sample |
| out_data | output | 16 | Signed scaled output sample |
| coarse_sel | input | 2 | Right-shift amount 0..3 (6.02 dB per step) |
| fine_gain | input | 16 | Unsigned fine gain, 32768 = unity |
| ramp_en | input | 1 | 1 = apply ramp gain, 0 = exact unity |
| ramp_last | input | 7 | Last valid ramp memory index |
| ramp_up | input | 1 | One-cycle ramp-up start strobe |
| ramp_down | input | 1 | One-cycle ramp-down start strobe |
| rmem_we | input | 1 | Ramp memory write enable |
| rmem_addr | input | 7 | Ramp memory write index |
| rmem_wdata | input | 14 | Ramp memory write word |

## Verification
A ramp memory write and a sample's gain-word read can land on the same index in the same cycle. To provoke this, the bench raises `rmem_we` with a new word for the held index at the same falling edge where it presents a sample to an empty pipeline. The result is judged by checking that this sample carries the old word and the very next sample carries the new one. A second coincidence is a control field change one cycle after a sample is accepted, while that sample is still in the first stage. It is judged by requiring the old gains on that sample.

// File: rtl/ost_pkg.sv
package ost_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_UP   = 2'd1,
    SEQ_DOWN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ost_round_sat.sv
module ost_round_sat #(
  parameter int IW = 33,
  parameter int OW = 16,
  parameter int SH = 15
) (
  input  logic signed [IW-1:0] din,
  output logic signed [OW-1:0] dout
);
  localparam logic signed [IW-1:0] HALF = IW'(1) << (SH - 1);
  localparam logic signed [IW-1:0] MAXV = {{(IW-OW+1){1'b0}}, {(OW-1){1'b1}}};
  localparam logic signed [IW-1:0] MINV = {{(IW-OW+1){1'b1}}, {(OW-1){1'b0}}};

  logic signed [IW-1:0] sum;
  logic signed [IW-1:0] shifted;

  always_comb begin
    sum     = din + HALF;
    shifted = sum >>> SH;
    if (shifted > MAXV)      dout = MAXV[OW-1:0];
    else if (shifted < MINV) dout = MINV[OW-1:0];
    else                     dout = shifted[OW-1:0];
  end
endmodule

// File: rtl/ost_gain_front.sv
module ost_gain_front #(
  parameter int DW = 16,
  parameter int FW = 16,
  parameter int RW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  input  logic [1:0]           coarse_sel,
  input  logic [FW-1:0]        fine_gain,
  input  logic                 bypass,
  input  logic [RW-1:0]        ramp_word,
  input  logic                 s1_ready,
  output logic                 s1_valid,
  output logic signed [DW-1:0] s1_data,
  output logic [RW-1:0]        s1_word,
  output logic                 s1_bypass
);
  localparam int PW = DW + FW + 1;

  logic signed [DW-1:0] shifted;
  logic signed [PW-1:0] a_ext, b_ext, prod;
  logic signed [DW-1:0] fine_out;

  assign shifted = in_data >>> coarse_sel;
  assign a_ext   = {{(PW-DW){shifted[DW-1]}}, shifted};
  assign b_ext   = {{(PW-FW){1'b0}}, fine_gain};
  assign prod    = a_ext * b_ext;

  ost_round_sat #(.IW(PW), .OW(DW), .SH(FW-1)) u_rs (
    .din (prod),
    .dout(fine_out)
  );

  assign in_ready = !s1_valid || s1_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_data   <= '0;
      s1_word   <= '0;
      s1_bypass <= 1'b1;
    end else if (in_ready) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_data   <= fine_out;
        s1_word   <= ramp_word;
        s1_bypass <= bypass;
      end
    end
  end

  assert_s1_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_ready) |=> (s1_valid && $stable(s1_data) && $stable(s1_word)));
endmodule

// File: rtl/ost_ramp_seq.sv
module ost_ramp_seq #(
  parameter int RW    = 14,
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [RW-1:0] wdata,
  input  logic          ramp_en,
  input  logic [AW-1:0] last_idx,
  input  logic          up_req,
  input  logic          down_req,
  input  logic          step,
  output logic [RW-1:0] word
);
  import ost_pkg::*;

  logic [RW-1:0] mem [DEPTH];
  seq_state_e    state_q;
  logic [AW-1:0] ptr_q;
  logic          hold_zero_q;
  logic [AW-1:0] rd_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    if (state_q == SEQ_IDLE) rd_idx = hold_zero_q ? '0 : last_idx;
    else                     rd_idx = ptr_q;
  end
  assign word = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SEQ_IDLE;
      ptr_q       <= '0;
      hold_zero_q <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (ramp_en && up_req) begin
            state_q <= SEQ_UP;
            ptr_q   <= '0;
          end else if (ramp_en && down_req) begin
            state_q <= SEQ_DOWN;
            ptr_q   <= last_idx;
          end
        end
        SEQ_UP: begin
          if (step) begin
            if (ptr_q >= last_idx) begin
              state_q     <= SEQ_IDLE;
              hold_zero_q <= 1'b0;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
          end
        end
        SEQ_DOWN: begin
          if (step) begin
            if (ptr_q == '0) begin
              state_q     <= SEQ_IDLE;
              hold_zero_q <= 1'b1;
            end else begin
              ptr_q <= ptr_q - 1'b1;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_busy_strobe_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != SEQ_IDLE && (up_req || down_req) && !step) |=> ($stable(state_q) && $stable(ptr_q)));

  assert_up_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_UP && step && ptr_q < last_idx) |=> (state_q == SEQ_UP && ptr_q == AW'($past(ptr_q) + 1'b1)));

  assert_down_ends_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_DOWN && step && ptr_q == '0) |=> (state_q == SEQ_IDLE && hold_zero_q));
endmodule

// File: rtl/ost_gain_back.sv
module ost_gain_back #(
  parameter int DW = 16,
  parameter int RW = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s1_valid,
  output logic                 s1_ready,
  input  logic signed [DW-1:0] s1_data,
  input  logic [RW-1:0]        s1_word,
  input  logic                 s1_bypass,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_data
);
  localparam int PW = DW + RW + 1;

  logic signed [PW-1:0] a_ext, w_ext, prod;
  logic signed [DW-1:0] ramp_out;
  logic signed [DW-1:0] next_data;
  logic [DW:0]          mag_in, mag_out;

  assign a_ext = {{(PW-DW){s1_data[DW-1]}}, s1_data};
  assign w_ext = {{(PW-RW){1'b0}}, s1_word};
  assign prod  = a_ext * w_ext;

  ost_round_sat #(.IW(PW), .OW(DW), .SH(RW)) u_rs (
    .din (prod),
    .dout(ramp_out)
  );

  assign next_data = s1_bypass ? s1_data : ramp_out;
  assign s1_ready  = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (s1_ready) begin
      out_valid <= s1_valid;
      if (s1_valid) out_data <= next_data;
    end
  end

  assign mag_in  = s1_data[DW-1]  ? -{s1_data[DW-1], s1_data}   : {1'b0, s1_data};
  assign mag_out = out_data[DW-1] ? -{out_data[DW-1], out_data} : {1'b0, out_data};

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_bypass_unity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_ready && s1_bypass) |=> (out_data == $past(s1_data)));

  assert_ramp_never_gains_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_ready && !s1_bypass) |=> (mag_out <= $past(mag_in)));
endmodule

// File: rtl/ost_gain_ramp.sv
module ost_gain_ramp #(
  parameter int DW    = 16,
  parameter int FW    = 16,
  parameter int RW    = 14,
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_data,
  input  logic [1:0]           coarse_sel,
  input  logic [FW-1:0]        fine_gain,
  input  logic                 ramp_en,
  input  logic [AW-1:0]        ramp_last,
  input  logic                 ramp_up,
  input  logic                 ramp_down,
  input  logic                 rmem_we,
  input  logic [AW-1:0]        rmem_addr,
  input  logic [RW-1:0]        rmem_wdata
);
  logic                 in_fire;
  logic [RW-1:0]        ramp_word;
  logic                 s1_valid, s1_ready, s1_bypass;
  logic signed [DW-1:0] s1_data;
  logic [RW-1:0]        s1_word;

  assign in_fire = in_valid && in_ready;

  ost_ramp_seq #(.RW(RW), .DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rmem_we),
    .waddr   (rmem_addr),
    .wdata   (rmem_wdata),
    .ramp_en (ramp_en),
    .last_idx(ramp_last),
    .up_req  (ramp_up),
    .down_req(ramp_down),
    .step    (in_fire),
    .word    (ramp_word)
  );

  ost_gain_front #(.DW(DW), .FW(FW), .RW(RW)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .coarse_sel(coarse_sel),
    .fine_gain (fine_gain),
    .bypass    (!ramp_en),
    .ramp_word (ramp_word),
    .s1_ready  (s1_ready),
    .s1_valid  (s1_valid),
    .s1_data   (s1_data),
    .s1_word   (s1_word),
    .s1_bypass (s1_bypass)
  );

  ost_gain_back #(.DW(DW), .RW(RW)) u_back (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_valid (s1_valid),
    .s1_ready (s1_ready),
    .s1_data  (s1_data),
    .s1_word  (s1_word),
    .s1_bypass(s1_bypass),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  assert_reset_idle_R1: assert property (@(posedge clk)
    (!rst_n) |=> (!out_valid && in_ready));
endmodule

// File: tb/ost_gain_ramp_tb_top.sv
`timescale 1ns/1ps
module ost_gain_ramp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic signed [15:0] in_data = '0;
  logic in_ready, out_valid;
  logic signed [15:0] out_data;
  logic [1:0]  coarse_sel = '0;
  logic [15:0] fine_gain = 16'd32768;
  logic        ramp_en = 1'b0;
  logic [6:0]  ramp_last = 7'd5;
  logic        ramp_up = 1'b0, ramp_down = 1'b0;
  logic        rmem_we = 1'b0;
  logic [6:0]  rmem_addr = '0;
  logic [13:0] rmem_wdata = '0;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  int got_q[$];
  int wmem[128];

  always #4 clk = ~clk;

  ost_gain_ramp dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .coarse_sel(coarse_sel), .fine_gain(fine_gain), .ramp_en(ramp_en), .ramp_last(ramp_last),
    .ramp_up(ramp_up), .ramp_down(ramp_down), .rmem_we(rmem_we), .rmem_addr(rmem_addr),
    .rmem_wdata(rmem_wdata)
  );

  always @(negedge clk) if (out_valid && out_ready) got_q.push_back(int'(out_data));

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int model(int x, int c, int f, bit en, int w);
    longint y1, y2;
    y1 = longint'(x) >>> c;
    y2 = sat16((y1 * f + 16384) >>> 15);
    if (!en) return int'(y2);
    return sat16((y2 * w + 8192) >>> 14);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(int x);
    in_data  = 16'(x);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_exp(int x, int w);
    exp_q.push_back(model(x, coarse_sel, fine_gain, ramp_en, w));
    send(x);
  endtask

  task automatic drain_and_compare(string req);
    repeat (8) @(negedge clk);
    check(req, got_q.size(), exp_q.size());
    foreach (exp_q[i]) if (i < got_q.size()) check(req, got_q[i], exp_q[i]);
    exp_q.delete();
    got_q.delete();
  endtask

  task automatic write_word(int a, int d);
    rmem_we = 1'b1; rmem_addr = 7'(a); rmem_wdata = 14'(d);
    @(negedge clk);
    rmem_we = 1'b0;
    wmem[a] = d;
  endtask

  task automatic pulse(bit up, bit down);
    ramp_up = up; ramp_down = down;
    @(negedge clk);
    ramp_up = 1'b0; ramp_down = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);
    for (int i = 0; i < 8; i++) write_word(i, 1000 + 2000 * i);
  endtask

  task automatic t_coarse_fine();
    ramp_en = 1'b0;
    for (int c = 0; c < 4; c++) begin
      coarse_sel = 2'(c);
      fine_gain = 16'd32768; send_exp(-12345, 0); send_exp(7, 0);
      fine_gain = 16'd12345; send_exp(20001, 0); send_exp(-3, 0);
    end
    drain_and_compare("R3 R4 R6 coarse/fine bypass");
  endtask

  task automatic t_saturate();
    ramp_en = 1'b0; coarse_sel = 0; fine_gain = 16'hFFFF;
    send_exp(30000, 0); send_exp(-30000, 0); send_exp(-32768, 0);
    drain_and_compare("R5 saturation");
    check("R5 positive clamp", model(30000, 0, 65535, 0, 0), 32767);
  endtask

  task automatic t_idle_hold();
    ramp_en = 1'b1; coarse_sel = 0; fine_gain = 16'd32768; ramp_last = 7'd5;
    send_exp(20000, wmem[5]); send_exp(-20000, wmem[5]); send_exp(32767, wmem[5]);
    drain_and_compare("R7 R8 idle word at last index");
  endtask

  task automatic t_collide();
    int old_w;
    old_w = wmem[5];
    exp_q.push_back(model(20000, 0, 32768, 1, old_w));
    in_data = 16'sd20000; in_valid = 1'b1;
    rmem_we = 1'b1; rmem_addr = 7'd5; rmem_wdata = 14'd16383;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; rmem_we = 1'b0; wmem[5] = 16383;
    send_exp(20000, 16383);
    drain_and_compare("R13 write/read same cycle");
  endtask

  task automatic t_ramp_up();
    ramp_en = 1'b1; ramp_last = 7'd5;
    pulse(1, 1);
    for (int i = 0; i <= 5; i++) send_exp(16000, wmem[i]);
    send_exp(16000, wmem[5]); send_exp(16000, wmem[5]);
    drain_and_compare("R9 ramp-up sequence then hold");
  endtask

  task automatic t_busy_ignore();
    pulse(1, 0);
    send_exp(16000, wmem[0]); send_exp(16000, wmem[1]);
    pulse(0, 1);
    send_exp(16000, wmem[2]);
    pulse(1, 0);
    for (int i = 3; i <= 5; i++) send_exp(16000, wmem[i]);
    send_exp(16000, wmem[5]);
    drain_and_compare("R11 strobe while stepping ignored");
  endtask

  task automatic t_ramp_down();
    pulse(0, 1);
    for (int i = 5; i >= 0; i--) send_exp(-16000, wmem[i]);
    send_exp(-16000, wmem[0]); send_exp(-16000, wmem[0]);
    drain_and_compare("R10 R8 ramp-down sequence then hold at index 0");
  endtask

  task automatic t_disabled_strobe();
    ramp_en = 1'b0;
    pulse(0, 1);
    ramp_en = 1'b1;
    send_exp(16000, wmem[0]); send_exp(16000, wmem[0]);
    drain_and_compare("R11 strobe with ramp disabled ignored");
  endtask

  task automatic t_backpressure();
    ramp_en = 1'b0; coarse_sel = 2'd1; fine_gain = 16'd40000;
    fork
      for (int i = 0; i < 20; i++) send_exp(i * 1500 - 14000, 0);
      for (int i = 0; i < 60; i++) begin
        @(posedge clk); #2;
        out_ready = (i % 3 != 0) && (i % 7 != 2);
      end
    join
    @(posedge clk); #2; out_ready = 1'b1;
    drain_and_compare("R2 order and count under back-pressure");
  endtask

  task automatic t_field_change();
    ramp_en = 1'b1; coarse_sel = 0; fine_gain = 16'd30000;
    send_exp(25000, wmem[0]);
    ramp_en = 1'b0; coarse_sel = 2'd2; fine_gain = 16'd50000;
    send_exp(25000, 0);
    drain_and_compare("R12 fields sampled at acceptance");
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_coarse_fine();
    t_saturate();
    t_idle_hold();
    t_collide();
    t_ramp_up();
    t_busy_ignore();
    t_ramp_down();
    t_disabled_strobe();
    t_backpressure();
    t_field_change();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule